// File: doc/BRIEF.md
# Flash Word-Program Engine

This block models the device side of a flash array's self-timed word programming. A host writes a four-step command sequence on a simple synchronous bus. The first three steps unlock the engine. The fourth step carries a target byte address and a 16-bit word, and it starts an internal programming run. The run can only clear bits: the stored word becomes the old word ANDed with the new data.

While a run is in progress, every read returns a status word instead of array data. Software polls this word to learn when the run has finished, or whether it has failed. A run that asks a stored 0 to become 1 cannot finish. It stays busy until a time limit runs out, then holds an error status until the host sends a reset command. A separate erase input sets every word to all ones. The array is word-addressed and kept small so that it suits simulation and synthesis.

Top module: `flash_word_prog`

## Requirements
- R1: A read pulse in read mode returns, on `bus_rdata` one cycle later, the word stored at `bus_addr[IDX_W:1]`. `bus_rdata` changes only after a read pulse, and a hardware reset clears it to 0.
- R2: A program run starts only on the fourth write of this sequence: 0xAAA/0x00AA, then 0x554/0x0055, then 0xAAA/0x00A0, then the target address and data. `busy` rises in the cycle after that fourth write.
- R3: A write whose address or data does not match the expected step sends the decoder back to its first step. The following write is then treated as the start of a new sequence, so it programs nothing.
- R4: A run on an even address with no 0-to-1 bit lasts exactly PROG_CYC cycles. It then stores old AND data and drops `busy`. Sequences may target any address in any order, and each one changes exactly one word.
- R5: While `busy` is high, a read returns this status word: bit 7 is the inverse of bit 7 of the programmed data, bit 5 is 0, and all other bits except bit 6 are 0. Bit 6 reads 0 on the first status read and inverts on every later read.
- R6: While `busy` is high, every bus write is ignored. This includes unlock steps, full sequences and 0x00F0.
- R7: A fourth write to an odd address leaves the array unchanged and enters the error state at once, with `busy` low. Status reads then show bit 5 = 1, bit 7 = the inverse of data bit 7, and bit 6 frozen.
- R8: A run whose data needs any 0-to-1 bit stays busy for exactly LIMIT_CYC cycles and then enters the error state. Bit 5 reads 1, bit 6 stops changing, and the stored word stays unchanged.
- R9: In the error state, reads return the status word and writes other than data 0x00F0 are ignored. A write of 0x00F0 to any address returns the block to read mode.
- R10: A hardware reset during a run returns the block to read mode with `busy` low and leaves the target word at its old value. Later sequences work normally.
- R11: A pulse on `erase_all` in read mode sets every word to 0xFFFF. A pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_re | input | 1 | Bus read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data or status word |
| erase_all | input | 1 | Sets the whole array to ones |
| busy | output | 1 | High while a program run is in progress |

## Verification
A wrong stage in the command decoder shows at the next sequence. Either `busy` fails to rise in the cycle after the fourth write, or a write that should be a stray write changes the array. The checks then read the target back to catch the difference. The timer is checked by sampling `busy` in the last busy cycle and the cycle after it, for both a normal run and a timed-out run, so an off-by-one count shows within one cycle. A toggle or error flag that is held wrong shows on the very next status read, because each read is compared against a value worked out from the read count and the data written.

// File: rtl/fwp_pkg.sv
// Shared types and fixed command encodings of the word-program engine.
// Assumes a 12-bit byte address bus and a 16-bit data bus.
package fwp_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        MODE_READ = 2'd0,
        MODE_PROG = 2'd1,
        MODE_FAIL = 2'd2
    } mode_t;

    localparam logic [ADDR_W-1:0] KEY_A_ADDR = 12'hAAA;
    localparam logic [DATA_W-1:0] KEY_A_DATA = 16'h00AA;
    localparam logic [ADDR_W-1:0] KEY_B_ADDR = 12'h554;
    localparam logic [DATA_W-1:0] KEY_B_DATA = 16'h0055;
    localparam logic [DATA_W-1:0] PROG_CODE  = 16'h00A0;
    localparam logic [DATA_W-1:0] RESET_CODE = 16'h00F0;
endpackage

// File: rtl/fwp_cmd_seq.sv
// Command sequence decoder. It tracks the three unlock steps and signals
// the fourth write as 'fire'. Assumes 'accept' is high only for writes
// that arrive in read mode.
module fwp_cmd_seq
    import fwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              fire
);
    logic [1:0] step;

    // The fourth write of a matched sequence starts a run.
    always_comb fire = accept && (step == 2'd3);

    // Advance on a matching step; drop to step 0 on any mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= 2'd0;
        end else if (accept) begin
            case (step)
                2'd0:    step <= (addr == KEY_A_ADDR && data == KEY_A_DATA) ? 2'd1 : 2'd0;
                2'd1:    step <= (addr == KEY_B_ADDR && data == KEY_B_DATA) ? 2'd2 : 2'd0;
                2'd2:    step <= (addr == KEY_A_ADDR && data == PROG_CODE)  ? 2'd3 : 2'd0;
                default: step <= 2'd0;
            endcase
        end
    end
endmodule

// File: rtl/fwp_timer.sv
// Busy-time counter. It counts while 'run' is high and flags the normal
// completion cycle and the time-limit cycle. Assumes PROG_CYC < LIMIT_CYC.
module fwp_timer #(
    parameter int PROG_CYC  = 16,
    parameter int LIMIT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic prog_done,
    output logic limit_hit
);
    localparam int CNT_W = $clog2(LIMIT_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Count busy cycles; restart from zero whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the last cycle of each window.
    always_comb begin
        prog_done = run && (cnt == CNT_W'(PROG_CYC - 1));
        limit_hit = run && (cnt == CNT_W'(LIMIT_CYC - 1));
    end
endmodule

// File: rtl/fwp_store.sv
// Word storage with one write port, one combinational read port and a
// whole-array erase. It has no reset, because the contents are meant to
// survive a hardware reset.
module fwp_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     erase,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_word,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_word
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Erase sets every word to ones; otherwise store the programmed word.
    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_word;
        end
    end

    // Asynchronous read of the addressed word.
    always_comb rd_word = mem[rd_idx];
endmodule

// File: rtl/flash_word_prog.sv
// Word-program engine top. It decodes the four-write command sequence,
// runs a timed program that ANDs data into one word, and answers reads
// with status while busy or failed. Assumes DEPTH is a power of two with
// $clog2(DEPTH) < 12, and that reads and writes are not issued together.
module flash_word_prog
    import fwp_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int PROG_CYC  = 16,
    parameter int LIMIT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              erase_all,
    output logic              busy
);
    localparam int IDX_W = $clog2(DEPTH);

    mode_t             mode;
    logic              fire;
    logic              cmd_ok;
    logic              prog_done;
    logic              limit_hit;
    logic              arr_we;
    logic              erase_ok;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_word;
    logic [IDX_W-1:0]  tgt_idx;
    logic [DATA_W-1:0] tgt_word;
    logic              tgt_bad;
    logic              tgt_d7;
    logic              tgl;
    logic [DATA_W-1:0] status;

    // Commands are decoded only in read mode.
    always_comb cmd_ok = bus_we && (mode == MODE_READ);

    // Word index taken from the byte address.
    always_comb rd_idx = bus_addr[IDX_W:1];

    // Commit a run only when it completes without a 0-to-1 request.
    always_comb arr_we = (mode == MODE_PROG) && prog_done && !tgt_bad;

    // Erase is honoured only in read mode.
    always_comb erase_ok = erase_all && (mode == MODE_READ);

    // Status word: inverted data bit 7, toggle bit 6, error bit 5.
    always_comb status = {8'h00, ~tgt_d7, tgl, (mode == MODE_FAIL), 5'b00000};

    // Busy output follows the running mode.
    always_comb busy = (mode == MODE_PROG);

    fwp_cmd_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (cmd_ok),
        .addr   (bus_addr),
        .data   (bus_wdata),
        .fire   (fire)
    );

    fwp_timer #(
        .PROG_CYC  (PROG_CYC),
        .LIMIT_CYC (LIMIT_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (mode == MODE_PROG),
        .prog_done (prog_done),
        .limit_hit (limit_hit)
    );

    fwp_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .erase   (erase_ok),
        .wr_en   (arr_we),
        .wr_idx  (tgt_idx),
        .wr_word (tgt_word),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    // Mode machine: start, finish, time out and recover program runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_READ;
            tgt_idx  <= '0;
            tgt_word <= '0;
            tgt_bad  <= 1'b0;
            tgt_d7   <= 1'b0;
            tgl      <= 1'b0;
        end else begin
            case (mode)
                MODE_READ: begin
                    if (fire) begin
                        tgt_idx  <= rd_idx;
                        tgt_word <= rd_word & bus_wdata;
                        tgt_bad  <= |(bus_wdata & ~rd_word);
                        tgt_d7   <= bus_wdata[7];
                        tgl      <= 1'b0;
                        mode     <= bus_addr[0] ? MODE_FAIL : MODE_PROG;
                    end
                end
                MODE_PROG: begin
                    if (bus_re) begin
                        tgl <= ~tgl;
                    end
                    if (tgt_bad && limit_hit) begin
                        mode <= MODE_FAIL;
                    end else if (!tgt_bad && prog_done) begin
                        mode <= MODE_READ;
                    end
                end
                MODE_FAIL: begin
                    if (bus_we && bus_wdata == RESET_CODE) begin
                        mode <= MODE_READ;
                    end
                end
                default: mode <= MODE_READ;
            endcase
        end
    end

    // Registered read port: array data in read mode, status otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= (mode == MODE_READ) ? rd_word : status;
        end
    end
endmodule

// File: rtl/fwp_chk.sv
// Property checker for the word-program engine, bound to the top module.
// It observes bus ports and the mode, toggle and array-write signals.
module fwp_chk
    import fwp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              busy,
    input mode_t             mode,
    input logic              tgl,
    input logic              arr_we
);
    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_we));

    // R4
    commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !busy);

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_re) |=> (tgl != $past(tgl)));

    // R8
    toggle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAIL) |=> $stable(tgl));

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAIL && !(bus_we && bus_wdata == RESET_CODE)) |=> (mode == MODE_FAIL));
endmodule

bind flash_word_prog fwp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .mode      (mode),
    .tgl       (tgl),
    .arr_we    (arr_we)
);

// File: tb/flash_word_prog_bench.sv
`timescale 1ns/1ps
module flash_word_prog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        erase_all = 1'b0;
    logic        busy;

    int          vecs = 0;
    int          errs = 0;
    logic        re_q = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    flash_word_prog u_flash_word_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .erase_all (erase_all),
        .busy      (busy)
    );

    // Remember which cycles carried a read.
    always @(posedge clk) re_q <= bus_re;

    // Monitor: compare each read result against the scoreboard.
    always @(negedge clk) begin
        if (re_q) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vecs++;
            if (bus_rdata !== e) begin
                errs++;
                $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", t, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Driver: issue a read and push the expected word.
    task automatic rd(input logic [11:0] a, input logic [15:0] e, input string t);
        bus_re = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic prog(input logic [11:0] a, input logic [15:0] d);
        wr(12'hAAA, 16'h00AA);
        wr(12'h554, 16'h0055);
        wr(12'hAAA, 16'h00A0);
        wr(a, d);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        chk("R10 reset busy", 16'(busy), 16'h0);
        chk("R1 reset rdata", bus_rdata, 16'h0000);

        // R11: erase sets all ones
        erase_all = 1'b1; idle(1); erase_all = 1'b0;
        rd(12'h000, 16'hFFFF, "R11 erased word 0");
        rd(12'h03E, 16'hFFFF, "R11 erased last word");

        // R2, R4, R5: normal run, exact busy window
        prog(12'h010, 16'h1234);
        chk("R2 busy after fourth write", 16'(busy), 16'h1);
        rd(12'h010, 16'h0080, "R5 first status");
        rd(12'h000, 16'h00C0, "R5 toggled status");
        idle(13);
        chk("R4 busy in last cycle", 16'(busy), 16'h1);
        idle(1);
        chk("R4 busy dropped", 16'(busy), 16'h0);
        rd(12'h010, 16'h1234, "R4 programmed word");

        // R4: AND semantics, any order
        prog(12'h010, 16'h1230); wait_ready();
        rd(12'h010, 16'h1230, "R4 bit cleared");
        prog(12'h03E, 16'h5A5A); wait_ready();
        prog(12'h002, 16'hA5A5); wait_ready();
        rd(12'h03E, 16'h5A5A, "R4 high word");
        rd(12'h002, 16'hA5A5, "R4 low word");
        rd(12'h010, 16'h1230, "R4 neighbour untouched");

        // R8, R6: 0-to-1 request times out; writes ignored while busy
        prog(12'h010, 16'hFFFF);
        rd(12'h010, 16'h0000, "R5 status d7 set");
        rd(12'h010, 16'h0040, "R5 status toggled");
        prog(12'h030, 16'h0000);
        wr(12'h000, 16'h00F0);
        chk("R6 still busy after writes", 16'(busy), 16'h1);
        idle(56);
        chk("R8 busy before limit", 16'(busy), 16'h1);
        idle(1);
        chk("R8 busy off at limit", 16'(busy), 16'h0);
        rd(12'h010, 16'h0020, "R8 error status");
        rd(12'h010, 16'h0020, "R8 toggle frozen");
        wr(12'hAAA, 16'h00AA);
        rd(12'h000, 16'h0020, "R9 stray write ignored");
        wr(12'h000, 16'h00F0);
        rd(12'h010, 16'h1230, "R8 word unchanged");
        rd(12'h030, 16'hFFFF, "R6 ignored sequence wrote nothing");

        // R7: odd target
        prog(12'h015, 16'h0000);
        chk("R7 not busy", 16'(busy), 16'h0);
        rd(12'h015, 16'h00A0, "R7 error status");
        rd(12'h015, 16'h00A0, "R7 status frozen");
        wr(12'h000, 16'h00F0);
        rd(12'h014, 16'hFFFF, "R7 word unchanged");

        // R3: broken sequences
        wr(12'hAAA, 16'h00AA); wr(12'h554, 16'h0055); wr(12'hAAA, 16'h00A1);
        wr(12'h020, 16'h0000);
        chk("R3 no run on bad code", 16'(busy), 16'h0);
        rd(12'h020, 16'hFFFF, "R3 bad code no write");
        wr(12'hAAA, 16'h00AA); wr(12'h556, 16'h0055); wr(12'hAAA, 16'h00A0);
        wr(12'h020, 16'h0000);
        rd(12'h020, 16'hFFFF, "R3 bad address no write");

        // R10: reset mid-run
        prog(12'h020, 16'h00FF);
        idle(3);
        rst_n = 1'b0; idle(1); rst_n = 1'b1;
        chk("R10 busy cleared", 16'(busy), 16'h0);
        chk("R10 rdata cleared", bus_rdata, 16'h0000);
        rd(12'h020, 16'hFFFF, "R10 old value kept");
        prog(12'h020, 16'h00FF); wait_ready();
        rd(12'h020, 16'h00FF, "R10 runs after reset");

        // R11: erase in read mode, ignored while busy
        erase_all = 1'b1; idle(1); erase_all = 1'b0;
        rd(12'h010, 16'hFFFF, "R11 erase word");
        rd(12'h020, 16'hFFFF, "R11 erase second word");
        prog(12'h006, 16'h3C3C); wait_ready();
        prog(12'h004, 16'h0F0F);
        erase_all = 1'b1; idle(1); erase_all = 1'b0;
        wait_ready();
        rd(12'h006, 16'h3C3C, "R11 erase ignored while busy");
        rd(12'h004, 16'h0F0F, "R11 run completed");

        idle(2);
        summary();
        $finish;
    end
endmodule